// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is a byte-wide bidirectional I/O port for a small microcontroller register bus. Software sees three registers: a pin-state register that returns the sampled pin levels, an output data latch that returns the stored drive value, and a direction register in which each bit decides whether its pin is an input (1) or a driven output (0). Pins are modelled as three separate vectors: output data, output enable, and a raw input that the block synchronizes before anyone can read it.

Because a latch read returns the stored value rather than the pin level, a read-modify-write on the latch cannot accidentally copy an input pin's level into the latch. A mode input hands the pad drivers to an external parallel-slave-port function, which then supplies both the drive data and the enables. Register writes made in that mode are still stored and take effect on the pads once the mode is left.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register reads 0xFF, the latch reads 0x00, `pin_oe` is 0, `pin_out` is 0 and `bus_rdata` is 0.
- R2: A write (`bus_wr` high at a clock edge) to address 0 or to address 1 loads `bus_wdata` into the output data latch.
- R3: With `psp_mode` low, `pin_out` equals the latch and each `pin_oe` bit is the inverse of its direction bit; a direction of 0xCF therefore gives `pin_oe` = 0x30.
- R4: A write to address 2 loads the direction register, and a read of address 2 returns it.
- R5: A read of address 0 returns `pin_in` through a two-flop synchronizer: a read captured at clock edge k returns the `pin_in` value sampled at edge k-2.
- R6: A read of address 1 returns the stored latch value, not the pin levels.
- R7: Reads of address 3 return 0, and writes to address 3 change neither the latch nor the direction register.
- R8: With `psp_mode` high, `pin_out` equals `psp_dout` and `pin_oe` equals `psp_oe`.
- R9: Latch and direction writes made while `psp_mode` is high are stored and drive the pads after `psp_mode` returns low.
- R10: `bus_rdata` is registered: it updates at a clock edge where `bus_rd` is high and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 pins, 1 latch, 2 direction, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels, asynchronous |
| pin_out | output | 8 | Pad output data |
| pin_oe | output | 8 | Pad output enable, 1 drives the pin |
| psp_mode | input | 1 | Hands pad drivers to the slave-port function |
| psp_dout | input | 8 | Slave-port drive data |
| psp_oe | input | 8 | Slave-port output enables |

## Verification
A corrupted latch or direction register shows at once on `pin_out` or `pin_oe`, in the same cycle as the faulty edge, and again one cycle later on `bus_rdata` when the register is read back. A synchronizer with a missing or extra stage shifts the cycle in which a new pin level first appears on a port read, so the bench reads back-to-back right after a pin change and expects the old value twice before the new one. A wrong mode select shows as the latch or the slave-port data leaking onto the pads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      REG_PINS  = 2'd0,
      REG_LATCH = 2'd1,
      REG_DIR   = 2'd2,
      REG_NONE  = 2'd3
   } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= raw_in;
         else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] DIR_RESET = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [WIDTH-1:0] pins_sync,
   output logic [WIDTH-1:0] bus_rdata,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q
);
   logic             hit_latch;
   logic             hit_dir;
   logic [WIDTH-1:0] rd_mux;

   assign hit_latch = bus_wr && (bus_addr == REG_PINS || bus_addr == REG_LATCH);
   assign hit_dir   = bus_wr && (bus_addr == REG_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         latch_q <= '0;
      else if (hit_latch) latch_q <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dir_q <= DIR_RESET;
      else if (hit_dir) dir_q <= bus_wdata;
   end

   always_comb begin
      unique case (bus_addr)
         REG_PINS:  rd_mux = pins_sync;
         REG_LATCH: rd_mux = latch_q;
         REG_DIR:   rd_mux = dir_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   p_latch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == REG_PINS || bus_addr == REG_LATCH)) |=> latch_q == $past(bus_wdata));

   p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_DIR) |=> dir_q == $past(bus_wdata));

   p_unused_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_NONE) |=> ($stable(latch_q) && $stable(dir_q)));

   p_latch_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == REG_LATCH && !bus_wr) |=> bus_rdata == $past(latch_q));

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int WIDTH = 8
) (
   input  logic             psp_mode,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] psp_dout,
   input  logic [WIDTH-1:0] psp_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign pin_out[b] = psp_mode ? psp_dout[b] : latch_q[b];
      assign pin_oe[b]  = psp_mode ? psp_oe[b]   : ~dir_q[b];
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   input  logic             bus_wr,
   input  logic             bus_rd,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   input  logic             psp_mode,
   input  logic [WIDTH-1:0] psp_dout,
   input  logic [WIDTH-1:0] psp_oe
);
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_port: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pin_in),
      .sync_out (pins_sync)
   );

   gpio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .pins_sync (pins_sync),
      .bus_rdata (bus_rdata),
      .latch_q   (latch_q),
      .dir_q     (dir_q)
   );

   gpio_pad_mux #(.WIDTH(WIDTH)) u_pads (
      .psp_mode (psp_mode),
      .latch_q  (latch_q),
      .dir_q    (dir_q),
      .psp_dout (psp_dout),
      .psp_oe   (psp_oe),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;
   logic       psp_mode = 1'b0;
   logic [7:0] psp_dout = '0;
   logic [7:0] psp_oe = '0;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   gpio_port dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .psp_mode(psp_mode),
      .psp_dout(psp_dout), .psp_oe(psp_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // each task starts and ends at a falling edge and spends one clock
   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      logic [7:0] rd;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pin_oe", pin_oe, 8'h00);
      chk("R1 pin_out", pin_out, 8'h00);
      chk("R1 rdata", bus_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(2'd2, rd); chk("R1 dir", rd, 8'hFF);
      bus_read(2'd1, rd); chk("R1 latch", rd, 8'h00);

      // R2 R6: all latch values via both addresses; pins held opposite
      for (int v = 0; v < 256; v++) begin
         pin_in = ~8'(v);
         bus_write(2'(v % 2), 8'(v));
         chk("R3 pin_out", pin_out, 8'(v));
         bus_read(2'd1, rd);
         chk("R2/R6 latch read", rd, 8'(v));
      end

      // R3 R4: all direction values
      for (int v = 0; v < 256; v++) begin
         bus_write(2'd2, 8'(v));
         chk("R3 pin_oe", pin_oe, ~8'(v));
         bus_read(2'd2, rd);
         chk("R4 dir read", rd, 8'(v));
      end
      bus_write(2'd2, 8'hCF);
      chk("R3 dir CF oe", pin_oe, 8'h30);

      // R5: sync delay exactly two clocks
      pin_in = 8'h3C;
      repeat (3) @(negedge clk);
      pin_in = 8'hC3;
      bus_read(2'd0, rd); chk("R5 first read old", rd, 8'h3C);
      bus_read(2'd0, rd); chk("R5 second read old", rd, 8'h3C);
      bus_read(2'd0, rd); chk("R5 third read new", rd, 8'hC3);
      for (int v = 0; v < 256; v++) begin
         pin_in = 8'(v);
         bus_read(2'd0, rd);
         bus_read(2'd0, rd);
         bus_read(2'd0, rd);
         chk("R5 pin sweep", rd, 8'(v));
      end

      // R7: unused address
      bus_write(2'd1, 8'h33);
      bus_write(2'd2, 8'h0F);
      bus_write(2'd3, 8'h5A);
      bus_read(2'd1, rd); chk("R7 latch kept", rd, 8'h33);
      bus_read(2'd2, rd); chk("R7 dir kept", rd, 8'h0F);
      bus_read(2'd3, rd); chk("R7 read zero", rd, 8'h00);

      // R10: rdata holds with no read strobe
      bus_read(2'd1, held);
      bus_write(2'd1, 8'hE7);
      bus_write(2'd2, 8'h81);
      pin_in = 8'h99;
      repeat (3) @(negedge clk);
      chk("R10 rdata hold", bus_rdata, held);

      // R8 R9: slave-port mode
      psp_mode = 1'b1; psp_dout = 8'hA5; psp_oe = 8'h3C;
      #1;
      chk("R8 psp pin_out", pin_out, 8'hA5);
      chk("R8 psp pin_oe", pin_oe, 8'h3C);
      @(negedge clk);
      bus_write(2'd1, 8'h77);
      bus_write(2'd2, 8'h11);
      chk("R8 pin_out unchanged", pin_out, 8'hA5);
      chk("R8 pin_oe unchanged", pin_oe, 8'h3C);
      psp_mode = 1'b0;
      #1;
      chk("R9 latch applied", pin_out, 8'h77);
      chk("R9 dir applied", pin_oe, 8'hEE);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule